// File: doc/BRIEF.md
# Power-Fail Store and Recall Sequencer

This block sequences the copy of a shadowed SRAM into its nonvolatile bank when power fails, and the copy back when power returns. It reads two supply-monitor comparator flags: one says the supply is above the switch threshold, the other says it is above the lower reset threshold. It also reads the write strobe of the SRAM port. From these it drives store-active and recall-active levels, a write-inhibit level, a busy flag and one-cycle copy strobes that start the array transfer engine.

A store is started only when the supply falls below the switch threshold and the array holds data written since the last store or recall; otherwise the block parks in its powered-down state. A recall request is latched whenever the supply is below the reset threshold, including out of reset, and it is served once the supply climbs back above the switch threshold. A shallow brown-out that never crosses the reset threshold therefore causes at most a store and never a recall. All durations are parameters counted in clock cycles.

Top module: `pfail_nv_ctrl`

## Requirements
- R1: While rst_ni is low the block is in the powered-down state with a recall pending: store_active_o, recall_active_o, busy_o and both copy strobes are 0 and wr_inhibit_o is 1.
- R2: When above_switch_i goes low in the idle state and at least one write was accepted since the last completed store or recall, store_active_o rises on the next clock edge.
- R3: A store keeps store_active_o high for DELAY_CYC + STORE_CYC cycles; store_copy_o pulses high for exactly one cycle, DELAY_CYC cycles after store_active_o rises.
- R4: When above_switch_i goes low with no write accepted since the last completed store or recall, no store occurs: store_active_o and busy_o stay 0.
- R5: When above_reset_i is low at any time, a recall request is latched; when above_switch_i is next high in the powered-down state, recall_active_o is high for RESTORE_CYC cycles starting one edge later, and recall_copy_o pulses once in its first cycle.
- R6: After a drop below the switch threshold that never goes below the reset threshold, the return of above_switch_i brings no recall: the block is idle with wr_inhibit_o low one edge later.
- R7: wr_inhibit_o is 1 whenever above_switch_i is 0 or a store, recall or power-down is in progress; a write strobe while wr_inhibit_o is 1 is ignored and does not make a later store happen.
- R8: The record of writes is cleared when a store or recall completes, so a following power drop with no new write starts no store.
- R9: busy_o is high exactly while store_active_o or recall_active_o is high; the block reports idle only once the running nonvolatile cycle has finished.
- R10: If above_switch_i falls during a recall, the recall is abandoned on the next edge, the request stays pending, and the next return above the switch threshold runs a full recall of RESTORE_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| above_switch_i | input | 1 | Supply is above the switch threshold |
| above_reset_i | input | 1 | Supply is above the reset threshold |
| wr_strobe_i | input | 1 | One-cycle pulse per SRAM write |
| store_active_o | output | 1 | Store (settle delay or copy) in progress |
| recall_active_o | output | 1 | Recall in progress |
| wr_inhibit_o | output | 1 | SRAM writes must be blocked |
| busy_o | output | 1 | A nonvolatile cycle is running |
| store_copy_o | output | 1 | One-cycle start strobe for the SRAM-to-shadow copy |
| recall_copy_o | output | 1 | One-cycle start strobe for the shadow-to-SRAM copy |

## Verification
Every registered result is due one clock edge after the input change that causes it: state changes, activity levels and copy strobes appear in the cycle after the supply flag moves, while wr_inhibit_o follows above_switch_i combinationally and is checked in the same cycle. Inputs are driven on the falling edge and outputs are sampled one nanosecond after the rising edge, so the first sample after a stimulus is index 0 of each window. A sweep over write-before-drop and deep-versus-shallow drop counts the cycles of store, recall and busy and the position of each copy strobe, and compares them with DELAY_CYC + STORE_CYC, RESTORE_CYC and DELAY_CYC computed in the bench.

// File: rtl/pfail_nv_pkg.sv
package pfail_nv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE         = 3'd0,
    ST_STORE_DELAY  = 3'd1,
    ST_STORING      = 3'd2,
    ST_POWERED_DOWN = 3'd3,
    ST_RECALLING    = 3'd4
  } pf_state_e;
endpackage

// File: rtl/pfail_op_timer.sv
module pfail_op_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             last_o,
  output logic             first_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + CNT_W'(1);
  end

  assign last_o  = en_i && (cnt_q == limit_i - CNT_W'(1));
  assign first_o = en_i && (cnt_q == '0);

  // R3
  no_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q < limit_i));
endmodule

// File: rtl/pfail_req_track.sv
module pfail_req_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_reset_i,
  input  logic wr_ok_i,
  input  logic store_done_i,
  input  logic recall_done_i,
  output logic dirty_o,
  output logic recall_req_o
);
  logic dirty_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dirty_q <= 1'b0;
      req_q   <= 1'b1;
    end else begin
      if (store_done_i || recall_done_i) dirty_q <= 1'b0;
      else if (wr_ok_i)                  dirty_q <= 1'b1;
      // a new low-supply event wins over completion
      if (below_reset_i)      req_q <= 1'b1;
      else if (recall_done_i) req_q <= 1'b0;
    end
  end

  assign dirty_o      = dirty_q;
  assign recall_req_o = req_q;

  // R7
  dirty_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dirty_q) |-> $past(wr_ok_i));
  // R8
  dirty_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_done_i || recall_done_i) |=> !dirty_q);
  // R5
  req_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    below_reset_i |=> req_q);
endmodule

// File: rtl/pfail_seq_fsm.sv
module pfail_seq_fsm
  import pfail_nv_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DELAY_CYC   = 4,
  parameter int STORE_CYC   = 16,
  parameter int RESTORE_CYC = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             above_switch_i,
  input  logic             dirty_i,
  input  logic             recall_req_i,
  input  logic             last_i,
  output pf_state_e        state_o,
  output logic             tmr_clr_o,
  output logic             tmr_en_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             store_done_o,
  output logic             recall_done_o
);
  pf_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (!above_switch_i) state_d = dirty_i ? ST_STORE_DELAY : ST_POWERED_DOWN;
      ST_STORE_DELAY:
        if (last_i) state_d = ST_STORING;
      ST_STORING:
        if (last_i) state_d = ST_POWERED_DOWN;
      ST_POWERED_DOWN:
        if (above_switch_i) state_d = recall_req_i ? ST_RECALLING : ST_IDLE;
      ST_RECALLING:
        if (!above_switch_i) state_d = ST_POWERED_DOWN;
        else if (last_i)     state_d = ST_IDLE;
      default: state_d = ST_POWERED_DOWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_POWERED_DOWN;
    else         state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_STORE_DELAY: limit_o = CNT_W'(DELAY_CYC);
      ST_STORING:     limit_o = CNT_W'(STORE_CYC);
      default:        limit_o = CNT_W'(RESTORE_CYC);
    endcase
  end

  assign tmr_clr_o     = (state_d != state_q);
  assign tmr_en_o      = (state_q == ST_STORE_DELAY) || (state_q == ST_STORING) ||
                         (state_q == ST_RECALLING);
  assign store_done_o  = (state_q == ST_STORING) && last_i;
  assign recall_done_o = (state_q == ST_RECALLING) && above_switch_i && last_i;
  assign state_o       = state_q;

  // R2
  store_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STORE_DELAY && $past(state_q) == ST_IDLE) |-> $past(dirty_i && !above_switch_i));
  // R5
  recall_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECALLING && $past(state_q) != ST_RECALLING) |-> $past(above_switch_i && recall_req_i));
  // R10
  recall_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECALLING && !above_switch_i) |=> state_q == ST_POWERED_DOWN);
endmodule

// File: rtl/pfail_nv_ctrl.sv
module pfail_nv_ctrl
  import pfail_nv_pkg::*;
#(
  parameter int DELAY_CYC   = 250,
  parameter int STORE_CYC   = 2_500_000,
  parameter int RESTORE_CYC = 137_500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic above_switch_i,
  input  logic above_reset_i,
  input  logic wr_strobe_i,
  output logic store_active_o,
  output logic recall_active_o,
  output logic wr_inhibit_o,
  output logic busy_o,
  output logic store_copy_o,
  output logic recall_copy_o
);
  localparam int MAX_A   = (DELAY_CYC > STORE_CYC) ? DELAY_CYC : STORE_CYC;
  localparam int MAX_CYC = (MAX_A > RESTORE_CYC) ? MAX_A : RESTORE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  pf_state_e        state;
  logic             tmr_clr, tmr_en, tmr_last, tmr_first;
  logic [CNT_W-1:0] limit;
  logic             store_done, recall_done, dirty, recall_req, wr_ok;

  pfail_seq_fsm #(
    .CNT_W(CNT_W), .DELAY_CYC(DELAY_CYC), .STORE_CYC(STORE_CYC), .RESTORE_CYC(RESTORE_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .above_switch_i,
    .dirty_i(dirty), .recall_req_i(recall_req), .last_i(tmr_last),
    .state_o(state), .tmr_clr_o(tmr_clr), .tmr_en_o(tmr_en), .limit_o(limit),
    .store_done_o(store_done), .recall_done_o(recall_done)
  );

  pfail_op_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .en_i(tmr_en), .limit_i(limit),
    .last_o(tmr_last), .first_o(tmr_first)
  );

  assign wr_inhibit_o = (state != ST_IDLE) || !above_switch_i;
  assign wr_ok        = wr_strobe_i && !wr_inhibit_o;

  pfail_req_track u_req (
    .clk_i, .rst_ni, .below_reset_i(!above_reset_i), .wr_ok_i(wr_ok),
    .store_done_i(store_done), .recall_done_i(recall_done),
    .dirty_o(dirty), .recall_req_o(recall_req)
  );

  assign store_active_o  = (state == ST_STORE_DELAY) || (state == ST_STORING);
  assign recall_active_o = (state == ST_RECALLING);
  assign busy_o          = tmr_en;
  assign store_copy_o    = (state == ST_STORING) && tmr_first;
  assign recall_copy_o   = (state == ST_RECALLING) && tmr_first;

  // R3
  store_copy_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_copy_o |=> !store_copy_o);
  // R9
  busy_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (store_active_o || recall_active_o));
  // R7
  inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !above_switch_i |-> wr_inhibit_o);
endmodule

// File: tb/pfail_nv_ctrl_tb.sv
module pfail_nv_ctrl_tb;
  localparam int DLY = 4;
  localparam int STO = 16;
  localparam int RST = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sw = 1'b0, rs = 1'b0, wr = 1'b0;
  logic sa, ra, inh, busy, sc, rc;
  int checks = 0, errors = 0;
  int n_sa, n_ra, n_busy, n_sc, n_rc, i_sc, i_rc, n_inh;
  bit busy_mismatch;

  always #2 clk = ~clk;

  pfail_nv_ctrl #(.DELAY_CYC(DLY), .STORE_CYC(STO), .RESTORE_CYC(RST)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .above_switch_i(sw), .above_reset_i(rs),
    .wr_strobe_i(wr), .store_active_o(sa), .recall_active_o(ra),
    .wr_inhibit_o(inh), .busy_o(busy), .store_copy_o(sc), .recall_copy_o(rc));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic observe(input int n);
    n_sa = 0; n_ra = 0; n_busy = 0; n_sc = 0; n_rc = 0; i_sc = -1; i_rc = -1; n_inh = 0;
    busy_mismatch = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      n_sa += int'(sa); n_ra += int'(ra); n_busy += int'(busy); n_inh += int'(inh);
      if (sc) begin n_sc++; if (i_sc < 0) i_sc = k; end
      if (rc) begin n_rc++; if (i_rc < 0) i_rc = k; end
      if (busy != (sa | ra)) busy_mismatch = 1;
    end
  endtask

  task automatic wr_pulse();
    @(negedge clk); wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic power_return(input bit deep);
    @(negedge clk); rs = 1'b1;
    @(negedge clk); sw = 1'b1;
    observe(RST + 4);
    chk(n_ra == (deep ? RST : 0), deep ? "R5 recall length" : "R6 no recall", n_ra, deep ? RST : 0);
    chk(n_rc == int'(deep), "R5 recall strobe count", n_rc, int'(deep));
    if (deep) chk(i_rc == 0, "R5 recall strobe position", i_rc, 0);
    chk(!busy_mismatch, "R9 busy tracks activity", n_busy, n_sa + n_ra);
    chk(inh == 1'b0, "R6 idle after return", int'(inh), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!sa && !ra && !busy && !sc && !rc, "R1 reset outputs", int'({sa, ra, busy, sc, rc}), 0);
    chk(inh == 1'b1, "R1 reset inhibit", int'(inh), 1);
    // power-up: recall pending from reset
    @(negedge clk); rst_ni = 1'b1; rs = 1'b1; sw = 1'b1;
    observe(RST + 4);
    chk(n_ra == RST, "R1 R5 power-up recall length", n_ra, RST);
    chk(n_rc == 1 && i_rc == 0, "R5 power-up recall strobe", i_rc, 0);
    chk(inh == 1'b0, "R9 idle after recall", int'(inh), 0);

    // sweep: write-before-drop x deep drop
    for (int d = 0; d < 2; d++) begin
      for (int dp = 0; dp < 2; dp++) begin
        if (d != 0) wr_pulse();
        @(negedge clk); sw = 1'b0; if (dp != 0) rs = 1'b0;
        observe(DLY + STO + 4);
        chk(n_sa == (d != 0 ? DLY + STO : 0), d != 0 ? "R2 R3 store length" : "R4 clean no store",
            n_sa, d != 0 ? DLY + STO : 0);
        chk(n_sc == d, "R3 store strobe count", n_sc, d);
        if (d != 0) chk(i_sc == DLY, "R3 store strobe position", i_sc, DLY);
        chk(n_busy == n_sa && !busy_mismatch, "R9 busy during store", n_busy, n_sa);
        chk(n_inh == DLY + STO + 4, "R7 inhibit while down", n_inh, DLY + STO + 4);
        wr_pulse();  // ignored while below switch
        power_return(dp != 0);
        // no write since last store/recall or since the ignored strobe
        @(negedge clk); sw = 1'b0;
        observe(DLY + STO + 2);
        chk(n_sa == 0, "R7 R8 no store after clear", n_sa, 0);
        power_return(1'b0);
      end
    end

    // write on the same cycle as the drop is inhibited
    @(negedge clk); sw = 1'b0; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    observe(DLY + STO);
    chk(n_sa == 0, "R7 write at drop ignored", n_sa, 0);
    power_return(1'b0);

    // writes during recall ignored; abort and rerun of recall
    @(negedge clk); sw = 1'b0; rs = 1'b0;
    @(negedge clk); rs = 1'b1;
    @(negedge clk); sw = 1'b1;
    observe(10);
    chk(n_ra == 10, "R5 recall running", n_ra, 10);
    @(negedge clk); wr = 1'b1;
    @(negedge clk); wr = 1'b0; sw = 1'b0;
    observe(4);
    chk(n_ra == 0, "R10 recall abandoned", n_ra, 0);
    @(negedge clk); sw = 1'b1;
    observe(RST + 4);
    chk(n_ra == RST, "R10 full recall rerun", n_ra, RST);
    @(negedge clk); sw = 1'b0;
    observe(DLY + STO);
    chk(n_sa == 0, "R7 write during recall ignored", n_sa, 0);
    power_return(1'b0);

    // shallow brown-out with dirty data: store then no recall
    wr_pulse();
    @(negedge clk); sw = 1'b0;
    observe(DLY + STO + 2);
    chk(n_sa == DLY + STO, "R2 R6 brown-out store", n_sa, DLY + STO);
    power_return(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule